// File: doc/BRIEF.md
# Interrupt Cause and Status Register for a Serial Port

This block collects the interrupt causes of a buffered serial port into one 32-bit status word and drives the interrupt line. The receive and transmit buffers and the serial engine sit outside the block. They supply single-cycle event pulses, the current line condition bits and the four modem control inputs. The block latches each event as a pending cause bit, but only while that cause's enable bit is set. The interrupt output is high while any cause is pending.

Several causes can be pending at the same time. Each one is a separate bit rather than a single prioritised code. The host reads the word and then acknowledges the causes it has handled by writing ones to the low byte. Changes on the modem inputs are caught as delta flags. For the ring indicator only the trailing (1 to 0) edge counts. The delta flags stay set until the host acknowledges the modem cause.

Top module: `intid_status_reg`

## Requirements
- R1: After reset, cause bits [4:0], delta bits [11:8] and `irqOut` are all 0.
- R2: Cause encoding in statusWord[4:0] is: bit0 line condition (`evLine`, gated by `cfgEnable[2]`), bit1 receive data (`evRxData`, gated by `cfgEnable[0]`), bit2 receive timeout (`evRxTimeout`, gated by `cfgEnable[0]`), bit3 transmit space (`evTxSpace`, gated by `cfgEnable[1]`), bit4 modem change (any new delta, gated by `cfgEnable[3]`). An enabled event sets its bit on the clock edge where it is sampled.
- R3: An event that arrives while its enable bit is 0 is dropped. Setting the enable bit later does not make it appear.
- R4: `irqOut` is 1 exactly when at least one of statusWord[4:0] is 1.
- R5: A write with `wrEn`=1 and `wrByteEn[0]`=1 clears each cause bit whose `wrData` bit in [4:0] is 1 and leaves the others alone. `wrData[7:5]` has no effect. A write with `wrByteEn[0]`=0 changes nothing.
- R6: When a cause is set and cleared on the same edge, it ends up set.
- R7: statusWord[11:8] holds delta flags for modemIn[0] (CTS), modemIn[1] (DSR), modemIn[2] (RI) and modemIn[3] (DCD), in that order. CTS, DSR and DCD flag either edge. RI flags only a 1-to-0 change. statusWord[15:12] shows the current modemIn[3:0].
- R8: Delta flags latch whether or not `cfgEnable[3]` is set. They clear when a write clears cause bit 4, unless a new delta arrives on that same edge.
- R9: statusWord[23:16] shows `lineStat[7:0]` unchanged. Bits [7:5] and [31:24] read as 0.
- R10: Under a mixed stream of events and acknowledgements, the causes set and clear independently of one another.
- R11: The modem input levels present on the first clock edge after reset are taken as the reference and produce no delta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 4 | Cause enables: 0 receive, 1 transmit space, 2 line condition, 3 modem |
| evLine | input | 1 | Line condition event pulse |
| evRxData | input | 1 | Receive data available pulse |
| evRxTimeout | input | 1 | Receive character timeout pulse |
| evTxSpace | input | 1 | Transmit space available pulse |
| modemIn | input | 4 | Synchronised modem inputs: CTS, DSR, RI, DCD |
| lineStat | input | 8 | Line condition bits from the serial engine |
| wrEn | input | 1 | Host write strobe |
| wrByteEn | input | 4 | Host write byte lanes |
| wrData | input | 32 | Host write data |
| statusWord | output | 32 | Assembled status word |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions assume that `modemIn` is already synchronous to `clk` and that reset is held low for at least one edge. The clear-write property is checked only on edges where none of the four event pulses is active, so it never has to arbitrate against R6. The random stimulus raises events with moderate probability, toggles each modem line freely and issues acknowledgement writes with random byte lanes and data. This covers the window where set and clear coincide, which the directed cases also target on purpose.

// File: rtl/intid_pkg.sv
package intid_pkg;
  localparam int ID_W    = 5;
  localparam int MODEM_W = 4;
  localparam int EN_W    = 4;
  localparam int LINE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int BE_W    = WORD_W / 8;

  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  localparam int ID_LS = 0;
  localparam int ID_RD = 1;
  localparam int ID_TO = 2;
  localparam int ID_TS = 3;
  localparam int ID_MS = 4;

  localparam int RI_IDX = 2;

  typedef struct packed {
    logic [ID_W-1:0]    setId;
    logic [ID_W-1:0]    clrId;
    logic [MODEM_W-1:0] setDelta;
    logic               clrDelta;
  } strobes_t;
endpackage

// File: rtl/intid_ctrl.sv
module intid_ctrl
  import intid_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [EN_W-1:0]    cfgEnable,
  input  logic               evLine,
  input  logic               evRxData,
  input  logic               evRxTimeout,
  input  logic               evTxSpace,
  input  logic [MODEM_W-1:0] modemIn,
  input  logic               wrEn,
  input  logic [BE_W-1:0]    wrByteEn,
  input  logic [ID_W-1:0]    wrLowBits,
  output strobes_t           strobes
);
  logic [MODEM_W-1:0] prevModem;
  logic               primed;
  logic [MODEM_W-1:0] deltaHit;
  logic               ackWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevModem <= '0;
      primed    <= 1'b0;
    end else begin
      prevModem <= modemIn;
      primed    <= 1'b1;
    end
  end

  for (genvar g = 0; g < MODEM_W; g++) begin : gDelta
    if (g == RI_IDX) begin : gTrail
      assign deltaHit[g] = primed & prevModem[g] & ~modemIn[g];
    end else begin : gAny
      assign deltaHit[g] = primed & (prevModem[g] ^ modemIn[g]);
    end
  end

  assign ackWrite = wrEn & wrByteEn[0];

  always_comb begin
    strobes.setDelta     = deltaHit;
    strobes.setId        = '0;
    strobes.setId[ID_LS] = evLine      & cfgEnable[EN_LS];
    strobes.setId[ID_RD] = evRxData    & cfgEnable[EN_RX];
    strobes.setId[ID_TO] = evRxTimeout & cfgEnable[EN_RX];
    strobes.setId[ID_TS] = evTxSpace   & cfgEnable[EN_TX];
    strobes.setId[ID_MS] = (|deltaHit) & cfgEnable[EN_MS];
    strobes.clrId        = ackWrite ? wrLowBits : '0;
    strobes.clrDelta     = ackWrite & wrLowBits[ID_MS];
  end
endmodule

// File: rtl/intid_datapath.sv
module intid_datapath
  import intid_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic [MODEM_W-1:0] modemIn,
  input  logic [LINE_W-1:0]  lineStat,
  output logic [WORD_W-1:0]  statusWord,
  output logic               irqOut
);
  localparam int PAD_LO = 8 - ID_W;
  localparam int PAD_HI = WORD_W - 16 - LINE_W;

  logic [ID_W-1:0]    pendId;
  logic [MODEM_W-1:0] deltaFlags;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendId     <= '0;
      deltaFlags <= '0;
    end else begin
      pendId <= (pendId & ~strobes.clrId) | strobes.setId;
      if (strobes.clrDelta) deltaFlags <= strobes.setDelta;
      else                  deltaFlags <= deltaFlags | strobes.setDelta;
    end
  end

  assign statusWord = {{PAD_HI{1'b0}}, lineStat, modemIn, deltaFlags,
                       {PAD_LO{1'b0}}, pendId};
  assign irqOut     = |pendId;
endmodule

// File: rtl/intid_status_reg.sv
module intid_status_reg
  import intid_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [EN_W-1:0]    cfgEnable,
  input  logic               evLine,
  input  logic               evRxData,
  input  logic               evRxTimeout,
  input  logic               evTxSpace,
  input  logic [MODEM_W-1:0] modemIn,
  input  logic [LINE_W-1:0]  lineStat,
  input  logic               wrEn,
  input  logic [BE_W-1:0]    wrByteEn,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  statusWord,
  output logic               irqOut
);
  strobes_t strobes;

  intid_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable),
    .evLine(evLine), .evRxData(evRxData), .evRxTimeout(evRxTimeout),
    .evTxSpace(evTxSpace), .modemIn(modemIn), .wrEn(wrEn),
    .wrByteEn(wrByteEn), .wrLowBits(wrData[ID_W-1:0]), .strobes(strobes)
  );

  intid_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modemIn(modemIn),
    .lineStat(lineStat), .statusWord(statusWord), .irqOut(irqOut)
  );
endmodule

// File: rtl/intid_checker.sv
module intid_checker
  import intid_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [EN_W-1:0]    cfgEnable,
  input logic               evLine,
  input logic               evRxData,
  input logic               evRxTimeout,
  input logic               evTxSpace,
  input logic [MODEM_W-1:0] modemIn,
  input logic               wrEn,
  input logic [BE_W-1:0]    wrByteEn,
  input logic [WORD_W-1:0]  wrData,
  input logic [WORD_W-1:0]  statusWord,
  input logic               irqOut
);
  p_irq_follows_causes_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (statusWord[ID_W-1:0] != '0));

  p_disabled_rx_stays_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable[EN_RX] && !statusWord[ID_RD]) |=> !statusWord[ID_RD]);

  p_enabled_rx_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (evRxData && cfgEnable[EN_RX]) |=> statusWord[ID_RD]);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrByteEn[0] && !evLine && !evRxData && !evRxTimeout && !evTxSpace)
      |=> ((statusWord[3:0] & $past(wrData[3:0])) == 4'b0));

  p_ri_rise_no_delta_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWord[8+RI_IDX] && modemIn[RI_IDX]) |=> !statusWord[8+RI_IDX]);

  p_delta_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrByteEn[0] && wrData[ID_MS] && modemIn == $past(modemIn))
      |=> statusWord[11:8] == 4'b0);
endmodule

bind intid_status_reg intid_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .evLine(evLine),
  .evRxData(evRxData), .evRxTimeout(evRxTimeout), .evTxSpace(evTxSpace),
  .modemIn(modemIn), .wrEn(wrEn), .wrByteEn(wrByteEn), .wrData(wrData),
  .statusWord(statusWord), .irqOut(irqOut)
);

// File: tb/sim_intid_status_reg.sv
`timescale 1ns/1ps
module sim_intid_status_reg;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  cfgEnable;
  logic        evLine, evRxData, evRxTimeout, evTxSpace;
  logic [3:0]  modemIn;
  logic [7:0]  lineStat;
  logic        wrEn;
  logic [3:0]  wrByteEn;
  logic [31:0] wrData;
  logic [31:0] statusWord;
  logic        irqOut;

  int nTests = 0;
  int nFail  = 0;

  logic [4:0] mId;
  logic [3:0] mDelta;
  logic [3:0] mPrev;
  logic       mPrimed;

  always #5 clk = ~clk;

  intid_status_reg u0 (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .evLine(evLine),
    .evRxData(evRxData), .evRxTimeout(evRxTimeout), .evTxSpace(evTxSpace),
    .modemIn(modemIn), .lineStat(lineStat), .wrEn(wrEn), .wrByteEn(wrByteEn),
    .wrData(wrData), .statusWord(statusWord), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord();
    return {8'h00, lineStat, modemIn, mDelta, 3'b000, mId};
  endfunction

  task automatic quiet();
    evLine = 0; evRxData = 0; evRxTimeout = 0; evTxSpace = 0;
    wrEn = 0; wrByteEn = 4'h0; wrData = '0;
  endtask

  // Inputs are set before this call; the model advances with the edge.
  task automatic step(string req);
    logic [3:0] newD;
    logic [4:0] newId, ack;
    for (int i = 0; i < 4; i++)
      newD[i] = mPrimed && ((i == 2) ? (mPrev[i] && !modemIn[i])
                                     : (mPrev[i] != modemIn[i]));
    newId = {(newD != 0) && cfgEnable[3], evTxSpace && cfgEnable[1],
             evRxTimeout && cfgEnable[0], evRxData && cfgEnable[0],
             evLine && cfgEnable[2]};
    ack = (wrEn && wrByteEn[0]) ? wrData[4:0] : 5'b0;
    @(posedge clk);
    mId     = newId | (mId & ~ack);
    mDelta  = ack[4] ? newD : (mDelta | newD);
    mPrev   = modemIn;
    mPrimed = 1'b1;
    #1;
    check(req, statusWord, expWord());
    check({req, "/R4"}, {31'b0, irqOut}, {31'b0, mId != 0});
    @(negedge clk);
    quiet();
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    quiet();
    rstN = 0; cfgEnable = 4'h0; lineStat = 8'h00;
    modemIn = 4'b0001;                 // CTS high through reset (R11)
    mId = '0; mDelta = '0; mPrev = '0; mPrimed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 and R11: first edge out of reset, CTS already high
    step("R1");
    check("R11", {28'b0, statusWord[11:8]}, 32'h0);
    step("R11");

    // R3: disabled events dropped, enabling later shows nothing
    evRxData = 1; evTxSpace = 1; evLine = 1; evRxTimeout = 1;
    step("R3");
    check("R3", {27'b0, statusWord[4:0]}, 32'h0);
    cfgEnable = 4'hF;
    step("R3");
    check("R3", {27'b0, statusWord[4:0]}, 32'h0);

    // R2: each cause on its own bit
    evLine = 1;      step("R2"); check("R2", {27'b0, statusWord[4:0]}, 32'h01);
    evRxData = 1;    step("R2"); check("R2", {27'b0, statusWord[4:0]}, 32'h03);
    evRxTimeout = 1; step("R2"); check("R2", {27'b0, statusWord[4:0]}, 32'h07);
    evTxSpace = 1;   step("R2"); check("R2", {27'b0, statusWord[4:0]}, 32'h0F);

    // R5: lane 0 off -> nothing; bits 7:5 -> nothing; partial clear
    wrEn = 1; wrByteEn = 4'b1110; wrData = 32'hFFFF_FFFF; step("R5");
    check("R5", {27'b0, statusWord[4:0]}, 32'h0F);
    wrEn = 1; wrByteEn = 4'b0001; wrData = 32'h0000_00E0; step("R5");
    check("R5", {27'b0, statusWord[4:0]}, 32'h0F);
    wrEn = 1; wrByteEn = 4'b0001; wrData = 32'h0000_0005; step("R5");
    check("R5", {27'b0, statusWord[4:0]}, 32'h0A);

    // R6: set and clear of bit1 on the same edge
    evRxData = 1; wrEn = 1; wrByteEn = 4'b0001; wrData = 32'h0000_001F;
    step("R6");
    check("R6", {27'b0, statusWord[4:0]}, 32'h02);
    wrEn = 1; wrByteEn = 4'b0001; wrData = 32'h1F; step("R5");

    // R7: RI rise no delta, RI fall flags, CTS falling edge flags
    modemIn = 4'b0101; step("R7");
    check("R7", {28'b0, statusWord[11:8]}, 32'h0);
    modemIn = 4'b0001; step("R7");
    check("R7", {28'b0, statusWord[11:8]}, 32'h4);
    check("R7", {31'b0, statusWord[4]}, 32'h1);
    modemIn = 4'b0000; step("R7");
    check("R7", {28'b0, statusWord[11:8]}, 32'h5);
    modemIn = 4'b1010; step("R7");
    check("R7", {28'b0, statusWord[15:8]}, 32'hAF);

    // R8: ack of cause 4 clears deltas; deltas latch with enable off
    wrEn = 1; wrByteEn = 4'b0001; wrData = 32'h10; step("R8");
    check("R8", {28'b0, statusWord[11:8]}, 32'h0);
    cfgEnable = 4'h7; modemIn = 4'b0010; step("R8");
    check("R8", {27'b0, statusWord[4:0]}, 32'h0);
    check("R8", {28'b0, statusWord[11:8]}, 32'h8);
    modemIn = 4'b0000; wrEn = 1; wrByteEn = 4'b0001; wrData = 32'h10;
    step("R8");
    check("R8", {28'b0, statusWord[11:8]}, 32'h2);
    cfgEnable = 4'hF;

    // R9: line condition pass-through and zero fields
    for (int k = 0; k < 8; k++) begin
      lineStat = 8'(1 << k) ^ 8'(k * 37);
      step("R9");
      check("R9", {statusWord[31:24], 21'b0, statusWord[7:5]}, 32'h0);
    end

    // R10: random mix
    for (int n = 0; n < 3000; n++) begin
      cfgEnable   = ($urandom % 8 == 0) ? 4'($urandom) : cfgEnable;
      evLine      = ($urandom % 4 == 0);
      evRxData    = ($urandom % 4 == 0);
      evRxTimeout = ($urandom % 5 == 0);
      evTxSpace   = ($urandom % 4 == 0);
      if ($urandom % 4 == 0) modemIn = 4'($urandom);
      lineStat    = 8'($urandom);
      wrEn        = ($urandom % 3 == 0);
      wrByteEn    = 4'($urandom);
      wrData      = $urandom;
      step("R10");
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule